// File: doc/BRIEF.md
# Shared-Bus Flash and Pseudo-SRAM Controller

This host-side controller owns one 16-bit data bus and a 22-bit address bus that are wired to two memory dies: a NOR-style flash and a pseudo-SRAM. The host presents one request at a time. Each request names the target die, says whether it is a read or a write, and carries an address, write data and two byte-lane enables. The controller drives the chip-enable, output-enable, write-enable and byte-lane strobes for the chosen die and holds them for a number of clock cycles set by a parameter for each die and direction. When the access ends it returns a one-cycle completion pulse, together with the read data captured in the last strobed cycle.

The two dies are never enabled in the same cycle. When a request targets a different die from the previous completed access, the controller inserts one extra cycle in which neither die is enabled. The flash sees all 22 address bits. The pseudo-SRAM only ever sees the shared low 20 bits, with the top two bits held at zero. Byte-lane gating is used only for the pseudo-SRAM.

A level input asks for pseudo-SRAM deep power-down. While the controller is idle and that input is high, it pulls the secondary pseudo-SRAM enable low. A pseudo-SRAM request arriving in this state, or the input being released, first raises that enable and then waits a parameterised number of wake-up cycles.

Top module: `dualmem_bus_ctrl`

## Requirements
- R1: The flash chip-enable `fl_ce_n` and the pseudo-SRAM primary enable `ps_ce1_n` are never low in the same cycle. Both are high whenever no access is in progress.
- R2: During a flash access `addr_o` carries all 22 request address bits. During a pseudo-SRAM access `addr_o[21:20]` is 0 and `addr_o[19:0]` carries the request address bits 19:0.
- R3: During a pseudo-SRAM access, `ps_bl_n[1]` is the inverse of `req_be[1]` and gates bus bits 15:8, and `ps_bl_n[0]` is the inverse of `req_be[0]` and gates bits 7:0. Outside such an access both are 1. A flash access ignores `req_be`.
- R4: A read holds the target's output enable low, its write enable high and `dq_oe` at 0. A write holds the write enable low, the output enable high and `dq_oe` at 1, with `dq_o` equal to the write data.
- R5: The target's strobes stay asserted for exactly FL_RD_WAIT, FL_WR_WAIT, PS_RD_WAIT or PS_WR_WAIT consecutive cycles, according to the die and the direction.
- R6: `done` is high for exactly one cycle, in the cycle after the last strobed cycle. For a read, `rdata` then holds the bus value of that last cycle. An erased flash location reads 16'hFFFF.
- R7: When the target differs from the target of the previous completed access, one cycle with both dies disabled comes before the strobes. After reset the previous target counts as flash.
- R8: With `pd_req` high and the controller idle, `ps_ce2` goes low while `ps_ce1_n` and both lane strobes stay high. Flash accesses leave `ps_ce2` low.
- R9: A pseudo-SRAM request made during deep power-down raises `ps_ce2` and waits PS_WAKE cycles before the strobes. Releasing `pd_req` with no request pending raises `ps_ce2` and holds `req_ready` low for PS_WAKE cycles.
- R10: `fl_rst_n` is low while `rst_n` is low and high after reset is released.
- R11: `req_ready` is high only when the controller is idle. An accepted request drops `req_ready` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_psram | input | 1 | 1 selects pseudo-SRAM, 0 selects flash |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 22 | Request address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 for bits 15:8, active high |
| pd_req | input | 1 | Pseudo-SRAM deep power-down request level |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data of the last read |
| addr_o | output | 22 | Memory address bus |
| dq_o | output | 16 | Data driven onto the bus |
| dq_oe | output | 1 | Bus driver enable |
| dq_i | input | 16 | Data read from the bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_rst_n | output | 1 | Flash reset, active low |
| ps_ce1_n | output | 1 | Pseudo-SRAM primary enable, active low |
| ps_ce2 | output | 1 | Pseudo-SRAM secondary enable, low is deep power-down |
| ps_oe_n | output | 1 | Pseudo-SRAM output enable, active low |
| ps_we_n | output | 1 | Pseudo-SRAM write enable, active low |
| ps_bl_n | output | 2 | Pseudo-SRAM lane enables, bit 1 upper, active low |

## Verification
The hardest state to reach is a pseudo-SRAM request that arrives while the die is in deep power-down and the previous access went to flash. In that case the turnaround cycle and the wake-up window must run back to back. The bench holds `pd_req` high and runs a flash read, so the die stays asleep and the last target is flash. It then issues a pseudo-SRAM read and measures the delay to the first strobe, which should be one turnaround cycle plus PS_WAKE cycles. It also checks that releasing `pd_req` alone stalls the host for exactly the wake-up window.

// File: rtl/dualmem_pkg.sv
package dualmem_pkg;
  localparam int ADDR_W   = 22;
  localparam int SHARED_W = 20;
  localparam int DATA_W   = 16;
  localparam int LANES    = DATA_W / 8;

  typedef enum logic {TGT_FLASH = 1'b0, TGT_PSRAM = 1'b1} tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_WAKE, ST_ACC, ST_FIN
  } st_e;

  typedef struct packed {
    tgt_e              tgt;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [LANES-1:0]  be;
  } req_t;
endpackage

// File: rtl/dualmem_cnt.sv
module dualmem_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dualmem_fsm.sv
module dualmem_fsm
  import dualmem_pkg::*;
#(
  parameter int FL_RD_WAIT = 3,
  parameter int FL_WR_WAIT = 2,
  parameter int PS_RD_WAIT = 2,
  parameter int PS_WR_WAIT = 3,
  parameter int PS_WAKE    = 5,
  parameter int CW         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  req_t              req_in,
  input  logic              pd_req,
  input  logic [DATA_W-1:0] dq_i,
  input  logic              cnt_zero,
  output logic              cnt_load,
  output logic [CW-1:0]     cnt_val,
  output st_e               state,
  output req_t              cur,
  output logic              sleeping,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  st_e  state_d;
  req_t cur_d;
  tgt_e last_q, last_d;
  logic sleep_d, wake_only_q, wake_only_d, rd_en;

  function automatic logic [CW-1:0] wait_of(input req_t r);
    int n;
    if (r.tgt == TGT_PSRAM) n = r.we ? PS_WR_WAIT : PS_RD_WAIT;
    else                    n = r.we ? FL_WR_WAIT : FL_RD_WAIT;
    return CW'(n - 1);
  endfunction

  always_comb begin
    state_d     = state;
    cur_d       = cur;
    sleep_d     = sleeping;
    last_d      = last_q;
    wake_only_d = wake_only_q;
    cnt_load    = 1'b0;
    cnt_val     = '0;
    rd_en       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          cur_d       = req_in;
          wake_only_d = 1'b0;
          if (req_in.tgt != last_q) begin
            state_d = ST_TURN;
          end else if (req_in.tgt == TGT_PSRAM && sleeping) begin
            state_d  = ST_WAKE;
            sleep_d  = 1'b0;
            cnt_load = 1'b1;
            cnt_val  = CW'(PS_WAKE - 1);
          end else begin
            state_d  = ST_ACC;
            cnt_load = 1'b1;
            cnt_val  = wait_of(req_in);
          end
        end else if (pd_req && !sleeping) begin
          sleep_d = 1'b1;
        end else if (!pd_req && sleeping) begin
          state_d     = ST_WAKE;
          sleep_d     = 1'b0;
          wake_only_d = 1'b1;
          cnt_load    = 1'b1;
          cnt_val     = CW'(PS_WAKE - 1);
        end
      end
      ST_TURN: begin
        cnt_load = 1'b1;
        if (cur.tgt == TGT_PSRAM && sleeping) begin
          state_d = ST_WAKE;
          sleep_d = 1'b0;
          cnt_val = CW'(PS_WAKE - 1);
        end else begin
          state_d = ST_ACC;
          cnt_val = wait_of(cur);
        end
      end
      ST_WAKE: begin
        if (cnt_zero) begin
          if (wake_only_q) begin
            state_d = ST_IDLE;
          end else begin
            state_d  = ST_ACC;
            cnt_load = 1'b1;
            cnt_val  = wait_of(cur);
          end
        end
      end
      ST_ACC: begin
        if (cnt_zero) begin
          state_d = ST_FIN;
          last_d  = cur.tgt;
          rd_en   = !cur.we;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur         <= '0;
      sleeping    <= 1'b0;
      last_q      <= TGT_FLASH;
      wake_only_q <= 1'b0;
    end else begin
      state       <= state_d;
      cur         <= cur_d;
      sleeping    <= sleep_d;
      last_q      <= last_d;
      wake_only_q <= wake_only_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= dq_i;
  end

  assign ready = (state == ST_IDLE);
  assign done  = (state == ST_FIN);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);
  // R9
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> state == ST_WAKE);
endmodule

// File: rtl/dualmem_pins.sv
module dualmem_pins
  import dualmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               state,
  input  req_t              cur,
  input  logic              sleeping,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic              ps_ce1_n,
  output logic              ps_ce2,
  output logic              ps_oe_n,
  output logic              ps_we_n,
  output logic [LANES-1:0]  ps_bl_n
);
  logic acc, fl_act, ps_act;

  assign acc    = (state == ST_ACC);
  assign fl_act = acc && (cur.tgt == TGT_FLASH);
  assign ps_act = acc && (cur.tgt == TGT_PSRAM);

  assign fl_ce_n  = !fl_act;
  assign fl_oe_n  = !(fl_act && !cur.we);
  assign fl_we_n  = !(fl_act && cur.we);
  assign ps_ce1_n = !ps_act;
  assign ps_ce2   = !sleeping;
  assign ps_oe_n  = !(ps_act && !cur.we);
  assign ps_we_n  = !(ps_act && cur.we);
  assign dq_oe    = acc && cur.we;
  assign dq_o     = dq_oe ? cur.wdata : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ps_bl_n[g] = !(ps_act && cur.be[g]);
  end

  always_comb begin
    addr_o = '0;
    if (fl_act)      addr_o = cur.addr;
    else if (ps_act) addr_o = {{(ADDR_W-SHARED_W){1'b0}}, cur.addr[SHARED_W-1:0]};
  end

  // R1
  excl_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_ce_n && !ps_ce1_n));
  // R7
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_ce_n |=> ps_ce1_n ##1 ps_ce1_n);
  // R2
  upper_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_ce1_n |-> addr_o[ADDR_W-1:SHARED_W] == '0);
  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_ce2 |-> (ps_ce1_n && (&ps_bl_n)));
  // R4
  drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (fl_oe_n && ps_oe_n));
endmodule

// File: rtl/dualmem_bus_ctrl.sv
module dualmem_bus_ctrl
  import dualmem_pkg::*;
#(
  parameter int FL_RD_WAIT = 3,
  parameter int FL_WR_WAIT = 2,
  parameter int PS_RD_WAIT = 2,
  parameter int PS_WR_WAIT = 3,
  parameter int PS_WAKE    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_psram,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              pd_req,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic              fl_rst_n,
  output logic              ps_ce1_n,
  output logic              ps_ce2,
  output logic              ps_oe_n,
  output logic              ps_we_n,
  output logic [LANES-1:0]  ps_bl_n
);
  localparam int M1   = (FL_RD_WAIT > FL_WR_WAIT) ? FL_RD_WAIT : FL_WR_WAIT;
  localparam int M2   = (PS_RD_WAIT > PS_WR_WAIT) ? PS_RD_WAIT : PS_WR_WAIT;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > PS_WAKE) ? M3 : PS_WAKE;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  req_t          req_in, cur;
  st_e           state;
  logic          sleeping, cnt_zero, cnt_load;
  logic [CW-1:0] cnt_val;

  assign req_in = '{tgt:   req_psram ? TGT_PSRAM : TGT_FLASH,
                    we:    req_we,
                    addr:  req_addr,
                    wdata: req_wdata,
                    be:    req_be};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_rst_n <= 1'b0;
    else        fl_rst_n <= 1'b1;
  end

  dualmem_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  dualmem_fsm #(
    .FL_RD_WAIT(FL_RD_WAIT), .FL_WR_WAIT(FL_WR_WAIT),
    .PS_RD_WAIT(PS_RD_WAIT), .PS_WR_WAIT(PS_WR_WAIT),
    .PS_WAKE(PS_WAKE), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(req_in),
    .pd_req(pd_req), .dq_i(dq_i), .cnt_zero(cnt_zero), .cnt_load(cnt_load),
    .cnt_val(cnt_val), .state(state), .cur(cur), .sleeping(sleeping),
    .ready(req_ready), .done(done), .rdata(rdata)
  );

  dualmem_pins u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .cur(cur), .sleeping(sleeping),
    .addr_o(addr_o), .dq_o(dq_o), .dq_oe(dq_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2), .ps_oe_n(ps_oe_n),
    .ps_we_n(ps_we_n), .ps_bl_n(ps_bl_n)
  );

  // R10
  flash_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_ce_n |-> fl_rst_n);
endmodule

// File: tb/dualmem_bus_ctrl_tb.sv
module dualmem_bus_ctrl_tb;
  localparam int FRW = 3, FWW = 2, PRW = 2, PWW = 3, WK = 5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_psram = 1'b0, req_we = 1'b0, pd_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, done, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [21:0] addr_o;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n;
  logic        ps_ce1_n, ps_ce2, ps_oe_n, ps_we_n;
  logic [1:0]  ps_bl_n;

  int n_cmp = 0, n_bad = 0, excl_bad = 0;
  bit last_ps = 1'b0, asleep = 1'b0;
  logic [15:0] pmem [16];
  logic [15:0] smem [16];

  always #2 clk = ~clk;

  dualmem_bus_ctrl #(.FL_RD_WAIT(FRW), .FL_WR_WAIT(FWW), .PS_RD_WAIT(PRW),
                     .PS_WR_WAIT(PWW), .PS_WAKE(WK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_psram(req_psram), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .pd_req(pd_req), .done(done),
    .rdata(rdata), .addr_o(addr_o), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n),
    .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2), .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n),
    .ps_bl_n(ps_bl_n)
  );

  // device models: erased flash, lane-gated pseudo-SRAM
  assign dq_i = (!fl_ce_n && !fl_oe_n && fl_rst_n) ? 16'hFFFF :
                (!ps_ce1_n && ps_ce2 && !ps_oe_n) ?
                  {ps_bl_n[1] ? 8'h00 : pmem[addr_o[3:0]][15:8],
                   ps_bl_n[0] ? 8'h00 : pmem[addr_o[3:0]][7:0]} : 16'h5A5A;

  always @(negedge clk) begin
    if (!ps_ce1_n && ps_ce2 && !ps_we_n) begin
      if (!ps_bl_n[1]) pmem[addr_o[3:0]][15:8] <= dq_o[15:8];
      if (!ps_bl_n[0]) pmem[addr_o[3:0]][7:0]  <= dq_o[7:0];
    end
    if (rst_n) begin
      if (!fl_ce_n && !ps_ce1_n) excl_bad++;
      if (dq_oe && (!fl_oe_n || !ps_oe_n)) excl_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit ps, input bit we, input logic [21:0] a,
                     input logic [15:0] wd, input logic [1:0] be,
                     input logic [15:0] exp_rd);
    int first, len, dk, exp_delay, exp_len;
    logic [15:0] rd;
    logic [21:0] exp_a;
    exp_delay = ((ps != last_ps) ? 1 : 0) + ((ps && asleep) ? WK : 0);
    exp_len   = ps ? (we ? PWW : PRW) : (we ? FWW : FRW);
    exp_a     = ps ? {2'b00, a[19:0]} : a;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_psram = ps; req_we = we;
    req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    // R11
    chk(req_ready == 1'b0, "R11 ready after accept", req_ready, 0);
    first = -1; len = 0; dk = -1; rd = '0;
    for (int k = 0; k < 60 && dk < 0; k++) begin
      if (ps ? !ps_ce1_n : !fl_ce_n) begin
        if (first < 0) begin
          first = k;
          chk(addr_o == exp_a, "R2 address", addr_o, exp_a);
          chk((ps ? ps_oe_n : fl_oe_n) == we, "R4 output enable", ps ? ps_oe_n : fl_oe_n, we);
          chk((ps ? ps_we_n : fl_we_n) == !we, "R4 write enable", ps ? ps_we_n : fl_we_n, !we);
          chk(dq_oe == we, "R4 bus drive", dq_oe, we);
          if (we) chk(dq_o == wd, "R4 write data", dq_o, wd);
          chk(ps_bl_n == (ps ? ~be : 2'b11), "R3 lane strobes", ps_bl_n, ps ? ~be : 2'b11);
          chk(ps_ce2 == (ps ? 1'b1 : !asleep), "R8 secondary enable", ps_ce2, ps ? 1 : !asleep);
          chk((ps ? fl_ce_n : ps_ce1_n) == 1'b1, "R1 other die off", ps ? fl_ce_n : ps_ce1_n, 1);
        end
        len++;
      end
      if (done) begin
        dk = k; rd = rdata;
        chk(fl_ce_n && ps_ce1_n, "R1 both off at done", {fl_ce_n, ps_ce1_n}, 2'b11);
      end else begin
        @(negedge clk);
      end
    end
    chk(first == exp_delay, "R7 R9 delay to strobe", first, exp_delay);
    chk(len == exp_len, "R5 strobe length", len, exp_len);
    chk(dk == exp_delay + exp_len, "R6 done position", dk, exp_delay + exp_len);
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", done, 0);
    if (!we) chk(rd == exp_rd, "R6 read data", rd, exp_rd);
    last_ps = ps;
    if (ps) asleep = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] wd, m;
    logic [1:0]  rb;
    int cnt;
    for (int i = 0; i < 16; i++) begin pmem[i] = 16'h0000; smem[i] = 16'h0000; end
    repeat (3) @(negedge clk);
    // R10
    chk(fl_rst_n == 1'b0, "R10 flash reset held", fl_rst_n, 0);
    chk(fl_ce_n && ps_ce1_n, "R1 reset disabled", {fl_ce_n, ps_ce1_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fl_rst_n == 1'b1, "R10 flash reset released", fl_rst_n, 1);
    chk(req_ready == 1'b1, "R11 idle ready", req_ready, 1);
    chk(done == 1'b0, "R6 no done at idle", done, 0);
    chk(ps_ce2 == 1'b1 && ps_bl_n == 2'b11, "R3 R8 idle strobes", {ps_ce2, ps_bl_n}, 3'b111);

    // byte-lane sweep: every address and enable pattern
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 4; b++) begin
        wd = 16'h1234 + 16'(a) * 16'h0101 + 16'(b) * 16'h2020;
        run(1'b1, 1'b1, 22'(a) | 22'h2A5500, wd, 2'(b), 16'h0);
        if (b[1]) smem[a][15:8] = wd[15:8];
        if (b[0]) smem[a][7:0]  = wd[7:0];
        rb = (b == 0) ? 2'b11 : 2'(b);
        m  = {rb[1] ? 8'hFF : 8'h00, rb[0] ? 8'hFF : 8'h00};
        run(1'b1, 1'b0, 22'(a), 16'h0, rb, smem[a] & m);
      end
    end

    // alternating dies: turnaround every time, erased flash
    for (int i = 0; i < 4; i++) begin
      run(1'b0, 1'b0, {2'(i), 20'hABC00 + 20'(i)}, 16'h0, 2'(i), 16'hFFFF);
      run(1'b1, 1'b0, 22'(i), 16'h0, 2'b11, smem[i]);
    end
    run(1'b0, 1'b1, 22'h3FFFFF, 16'hA55A, 2'b00, 16'h0);
    run(1'b0, 1'b0, 22'h3FFFFF, 16'h0, 2'b11, 16'hFFFF);

    // deep power-down
    pd_req = 1'b1;
    repeat (3) @(negedge clk);
    asleep = 1'b1;
    chk(ps_ce2 == 1'b0 && ps_ce1_n == 1'b1, "R8 deep power-down", {ps_ce2, ps_ce1_n}, 2'b01);
    run(1'b0, 1'b0, 22'h300001, 16'h0, 2'b11, 16'hFFFF);
    chk(ps_ce2 == 1'b0, "R8 still asleep after flash", ps_ce2, 0);
    run(1'b1, 1'b0, 22'h000005, 16'h0, 2'b11, smem[5]);
    repeat (3) @(negedge clk);
    asleep = 1'b1;
    chk(ps_ce2 == 1'b0, "R8 re-entered sleep", ps_ce2, 0);
    run(1'b1, 1'b1, 22'h000006, 16'hBEEF, 2'b11, 16'h0);
    smem[6] = 16'hBEEF;
    repeat (3) @(negedge clk);
    asleep = 1'b1;
    pd_req = 1'b0;
    @(negedge clk);
    cnt = 0;
    chk(ps_ce2 == 1'b1, "R9 enable raised on release", ps_ce2, 1);
    while (!req_ready && cnt < 50) begin cnt++; @(negedge clk); end
    asleep = 1'b0;
    chk(cnt == WK, "R9 wake stall length", cnt, WK);
    run(1'b1, 1'b0, 22'h000006, 16'h0, 2'b11, 16'hBEEF);

    chk(excl_bad == 0, "R1 R4 bus monitor", excl_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule